// File: doc/BRIEF.md
# Stack and Memory Instruction Unit

This unit carries out the memory sub-operation of a wide instruction word. It owns a private data RAM and a stack pointer, and it works on a shared bus value that the rest of the datapath reads after it. Each executed step takes a 3-bit opcode, two 8-bit immediates (called IP and P here) and the incoming bus value. It returns the updated bus value and the current stack pointer. The memory sub-operation runs first in an instruction, so the arithmetic, logic and control sub-operations that follow all see the bus value this unit produces.

The bus value is never cleared. When an operation does not write to it, the incoming value passes through unchanged, so the bus behaves like an accumulator. The stack pointer can be loaded from the bus, which makes it the only path for indirect addressing. Push and pop reach any RAM word through it. Direct load and store use the low bits of P as a fixed address. The data RAM is separate from any instruction store and holds only data words.

Top module: `stack_mem_unit`

## Requirements
- R1: While the reset is asserted and after it is released, with no step executed, `sp_out` is 0 and `bus_out` is 0.
- R2: Opcode 3'b000 (no-op) with `exec_en` high makes `bus_out` equal the incoming `bus_in` after the clock edge. The stack pointer and the RAM are left unchanged.
- R3: Opcode 3'b011 (push bus) first decrements SP by one. It then writes `bus_in` to RAM at the new SP, and the bus passes `bus_in` through.
- R4: Opcode 3'b001 (pop) loads `bus_out` with the RAM word at the current SP and then increments SP by one. Values come back in last-in, first-out order.
- R5: Opcode 3'b101 (push IP) pushes `imm_ip` zero-extended to 28 bits, with the same SP movement as R3.
- R6: Opcode 3'b111 (push P) pushes `imm_p` zero-extended to 28 bits, with the same SP movement as R3.
- R7: Opcode 3'b010 loads SP with `bus_in`. The bus passes `bus_in` through.
- R8: Opcode 3'b110 (store) writes `bus_in` to RAM at address `imm_p[6:0]`. SP does not change, and the bus passes `bus_in` through.
- R9: Opcode 3'b100 (load) sets `bus_out` to the RAM word at `imm_p[6:0]`. Bit 7 of P plays no part in the address, and SP does not change.
- R10: Only SP bits [6:0] address the RAM. The upper SP bits are kept in full in `sp_out` but do not change which word a push or pop reaches.
- R11: With `exec_en` low, `bus_out`, `sp_out` and the RAM contents all hold, whatever the opcode.
- R12: SP arithmetic wraps over 28 bits. A push at SP 0 gives SP 0xFFFFFFF and writes RAM word 127. A pop at 0xFFFFFFF returns SP to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Executes one memory sub-operation at this clock edge |
| opcode | input | 3 | Memory sub-operation code |
| imm_ip | input | 8 | First immediate of the instruction word |
| imm_p | input | 8 | Second immediate: push value or direct address |
| bus_in | input | 28 | Incoming shared bus value |
| bus_out | output | 28 | Updated shared bus value, registered |
| sp_out | output | 28 | Current stack pointer |

## Verification
The bench builds the unit with its default parameters: 28-bit data, a 7-bit RAM address (128 words) and 8-bit immediates. With these values the immediate is one bit wider than the RAM address, so a direct address with P bit 7 set shows that the extra bit is ignored. The stack pointer is far wider than the address, so SP values whose upper bits are set, and the full 28-bit wrap from 0 to 0xFFFFFFF landing on word 127, are both reachable in a few steps.

// File: rtl/smu_pkg.sv
package smu_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'b000,
    OP_POP    = 3'b001,
    OP_SPLD   = 3'b010,
    OP_PUSHB  = 3'b011,
    OP_LDDIR  = 3'b100,
    OP_PUSHIP = 3'b101,
    OP_STDIR  = 3'b110,
    OP_PUSHP  = 3'b111
  } mem_op_e;

  typedef enum logic [1:0] {
    ADR_SP     = 2'd0,
    ADR_SPDEC  = 2'd1,
    ADR_DIRECT = 2'd2
  } adr_sel_e;

  typedef enum logic [1:0] {
    WD_BUS = 2'd0,
    WD_IP  = 2'd1,
    WD_P   = 2'd2
  } wd_sel_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_INC  = 2'd1,
    SP_DEC  = 2'd2,
    SP_LOAD = 2'd3
  } sp_act_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    adr_sel_e adr;
    wd_sel_e  wd;
    sp_act_e  sp;
  } mem_ctl_t;

endpackage

// File: rtl/smu_rst_sync.sv
module smu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/smu_decode.sv
module smu_decode
  import smu_pkg::*;
(
  input  logic [2:0] opcode,
  output mem_ctl_t   ctl
);

  always_comb begin
    ctl = '{rd: 1'b0, wr: 1'b0, adr: ADR_SP, wd: WD_BUS, sp: SP_HOLD};
    case (mem_op_e'(opcode))
      OP_POP: begin
        ctl.rd  = 1'b1;
        ctl.adr = ADR_SP;
        ctl.sp  = SP_INC;
      end
      OP_SPLD: begin
        ctl.sp = SP_LOAD;
      end
      OP_PUSHB: begin
        ctl.wr  = 1'b1;
        ctl.adr = ADR_SPDEC;
        ctl.wd  = WD_BUS;
        ctl.sp  = SP_DEC;
      end
      OP_LDDIR: begin
        ctl.rd  = 1'b1;
        ctl.adr = ADR_DIRECT;
      end
      OP_PUSHIP: begin
        ctl.wr  = 1'b1;
        ctl.adr = ADR_SPDEC;
        ctl.wd  = WD_IP;
        ctl.sp  = SP_DEC;
      end
      OP_STDIR: begin
        ctl.wr  = 1'b1;
        ctl.adr = ADR_DIRECT;
        ctl.wd  = WD_BUS;
      end
      OP_PUSHP: begin
        ctl.wr  = 1'b1;
        ctl.adr = ADR_SPDEC;
        ctl.wd  = WD_P;
        ctl.sp  = SP_DEC;
      end
      default: begin
        ctl = '{rd: 1'b0, wr: 1'b0, adr: ADR_SP, wd: WD_BUS, sp: SP_HOLD};
      end
    endcase
  end

endmodule

// File: rtl/smu_sp.sv
module smu_sp
  import smu_pkg::*;
#(
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  sp_act_e           act,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] sp_minus
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] sp_d;
  logic [DATA_W-1:0] sp_plus;

  assign sp_minus = sp_q - ONE;
  assign sp_plus  = sp_q + ONE;

  always_comb begin
    sp_d = sp_q;
    if (en) begin
      case (act)
        SP_INC:  sp_d = sp_plus;
        SP_DEC:  sp_d = sp_minus;
        SP_LOAD: sp_d = load_val;
        default: sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

endmodule

// File: rtl/smu_ram.sv
module smu_ram #(
  parameter int DATA_W = 28,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/stack_mem_unit.sv
module stack_mem_unit
  import smu_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int ADDR_W = 7,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [2:0]        opcode,
  input  logic [IMM_W-1:0]  imm_ip,
  input  logic [IMM_W-1:0]  imm_p,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] sp_out
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic              rst_sync_n;
  mem_ctl_t          ctl;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] sp_minus;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [DATA_W-1:0] bus_d;
  logic [DATA_W-1:0] bus_q;

  smu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smu_decode u_dec (
    .opcode (opcode),
    .ctl    (ctl)
  );

  smu_sp #(.DATA_W(DATA_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (exec_en),
    .act      (ctl.sp),
    .load_val (bus_in),
    .sp_q     (sp_q),
    .sp_minus (sp_minus)
  );

  always_comb begin
    case (ctl.adr)
      ADR_SPDEC:  ram_addr = sp_minus[ADDR_W-1:0];
      ADR_DIRECT: ram_addr = imm_p[ADDR_W-1:0];
      default:    ram_addr = sp_q[ADDR_W-1:0];
    endcase
  end

  always_comb begin
    case (ctl.wd)
      WD_IP:   ram_wdata = {{PAD_W{1'b0}}, imm_ip};
      WD_P:    ram_wdata = {{PAD_W{1'b0}}, imm_p};
      default: ram_wdata = bus_in;
    endcase
  end

  assign ram_we = exec_en & ctl.wr;

  smu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    bus_d = bus_q;
    if (exec_en) begin
      bus_d = ctl.rd ? ram_rdata : bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_q <= '0;
    end else begin
      bus_q <= bus_d;
    end
  end

  assign bus_out = bus_q;
  assign sp_out  = sp_q;

endmodule

// File: rtl/smu_chk.sv
module smu_chk #(
  parameter int DATA_W = 28,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_en,
  input logic [2:0]        opcode,
  input logic [IMM_W-1:0]  imm_ip,
  input logic [IMM_W-1:0]  imm_p,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] sp_out,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  assert_nop_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b000 |=> bus_out == $past(bus_in) && sp_out == $past(sp_out));

  assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (opcode == 3'b011 || opcode == 3'b101 || opcode == 3'b111)
    |=> sp_out == $past(sp_out) - ONE);

  assert_pop_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b001 |=> sp_out == $past(sp_out) + ONE);

  assert_push_ip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b101 |-> ram_we && ram_wdata == {{(DATA_W-IMM_W){1'b0}}, imm_ip});

  assert_push_p_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b111 |-> ram_we && ram_wdata == {{(DATA_W-IMM_W){1'b0}}, imm_p});

  assert_sp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b010 |=> sp_out == $past(bus_in) && bus_out == $past(bus_in));

  assert_direct_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (opcode == 3'b100 || opcode == 3'b110) |=> $stable(sp_out));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(sp_out) && $stable(bus_out));

  assert_idle_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !ram_we);

  assert_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode == 3'b011 && sp_out == '0 |=> sp_out == '1);

endmodule

bind stack_mem_unit smu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .exec_en   (exec_en),
  .opcode    (opcode),
  .imm_ip    (imm_ip),
  .imm_p     (imm_p),
  .bus_in    (bus_in),
  .bus_out   (bus_out),
  .sp_out    (sp_out),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata)
);

// File: tb/stack_mem_unit_tb.sv
module stack_mem_unit_tb;

  localparam int DW = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          exec_en;
  logic [2:0]    opcode;
  logic [7:0]    imm_ip;
  logic [7:0]    imm_p;
  logic [DW-1:0] bus_in;
  logic [DW-1:0] bus_out;
  logic [DW-1:0] sp_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stack_mem_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en),
    .opcode  (opcode),
    .imm_ip  (imm_ip),
    .imm_p   (imm_p),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .sp_out  (sp_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at the following negedge
  task automatic step(input logic en, input logic [2:0] op, input logic [7:0] ip,
                      input logic [7:0] p, input logic [DW-1:0] b);
    exec_en = en;
    opcode  = op;
    imm_ip  = ip;
    imm_p   = p;
    bus_in  = b;
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    exec_en = 1'b0; opcode = 3'b000; imm_ip = '0; imm_p = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    chk("R1", "sp in reset", sp_out, 28'h0);
    chk("R1", "bus in reset", bus_out, 28'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sp after release", sp_out, 28'h0);
    chk("R1", "bus after release", bus_out, 28'h0);
  endtask

  task automatic t_nop;
    step(1'b1, 3'b000, 8'h11, 8'h22, 28'h1234567);
    chk("R2", "nop bus", bus_out, 28'h1234567);
    chk("R2", "nop sp", sp_out, 28'h0);
  endtask

  task automatic t_sp_load;
    step(1'b1, 3'b010, 8'h00, 8'h00, 28'h0000040);
    chk("R7", "sp loaded", sp_out, 28'h0000040);
    chk("R7", "bus passes", bus_out, 28'h0000040);
  endtask

  task automatic t_push_pop;
    step(1'b1, 3'b011, 8'h00, 8'h00, 28'hABCDEF1);
    chk("R3", "sp after push 1", sp_out, 28'h000003F);
    chk("R3", "bus passes on push", bus_out, 28'hABCDEF1);
    step(1'b1, 3'b011, 8'h00, 8'h00, 28'h7654321);
    chk("R3", "sp after push 2", sp_out, 28'h000003E);
    step(1'b1, 3'b001, 8'h00, 8'h00, 28'h0);
    chk("R4", "pop newest", bus_out, 28'h7654321);
    chk("R4", "sp after pop 1", sp_out, 28'h000003F);
    step(1'b1, 3'b001, 8'h00, 8'h00, 28'h0);
    chk("R4", "pop older", bus_out, 28'hABCDEF1);
    chk("R4", "sp after pop 2", sp_out, 28'h0000040);
  endtask

  task automatic t_push_imm;
    step(1'b1, 3'b101, 8'hA5, 8'h3C, 28'hFFFFFFF);
    chk("R5", "sp after push ip", sp_out, 28'h000003F);
    step(1'b1, 3'b111, 8'h5A, 8'hFF, 28'hFFFFFFF);
    chk("R6", "sp after push p", sp_out, 28'h000003E);
    step(1'b1, 3'b001, 8'h00, 8'h00, 28'hFFFFFFF);
    chk("R6", "pushed p zero-extended", bus_out, 28'h00000FF);
    step(1'b1, 3'b001, 8'h00, 8'h00, 28'hFFFFFFF);
    chk("R5", "pushed ip zero-extended", bus_out, 28'h00000A5);
    chk("R5", "sp restored", sp_out, 28'h0000040);
  endtask

  task automatic t_direct;
    step(1'b1, 3'b110, 8'h00, 8'h05, 28'h0FEDCBA);
    chk("R8", "store sp unchanged", sp_out, 28'h0000040);
    chk("R8", "store bus passes", bus_out, 28'h0FEDCBA);
    step(1'b1, 3'b000, 8'h00, 8'h00, 28'h0);
    step(1'b1, 3'b100, 8'h00, 8'h85, 28'h1111111);
    chk("R9", "load ignores P bit 7", bus_out, 28'h0FEDCBA);
    chk("R9", "load sp unchanged", sp_out, 28'h0000040);
  endtask

  task automatic t_upper_bits;
    step(1'b1, 3'b010, 8'h00, 8'h00, 28'h1000003);
    step(1'b1, 3'b011, 8'h00, 8'h00, 28'h1111111);
    chk("R10", "sp keeps upper bits", sp_out, 28'h1000002);
    step(1'b1, 3'b100, 8'h00, 8'h02, 28'h0);
    chk("R10", "push hit word 2", bus_out, 28'h1111111);
  endtask

  task automatic t_idle;
    step(1'b0, 3'b110, 8'h00, 8'h02, 28'h2222222);
    chk("R11", "idle bus holds", bus_out, 28'h1111111);
    chk("R11", "idle sp holds", sp_out, 28'h1000002);
    step(1'b0, 3'b010, 8'h00, 8'h00, 28'h3000000);
    chk("R11", "idle sp load ignored", sp_out, 28'h1000002);
    step(1'b1, 3'b000, 8'h00, 8'h00, 28'h0);
    step(1'b1, 3'b100, 8'h00, 8'h02, 28'h0);
    chk("R11", "idle store ignored", bus_out, 28'h1111111);
  endtask

  task automatic t_wrap;
    step(1'b1, 3'b010, 8'h00, 8'h00, 28'h0);
    step(1'b1, 3'b011, 8'h00, 8'h00, 28'h3333333);
    chk("R12", "sp wraps down", sp_out, 28'hFFFFFFF);
    step(1'b1, 3'b100, 8'h00, 8'h7F, 28'h0);
    chk("R12", "push landed in word 127", bus_out, 28'h3333333);
    step(1'b1, 3'b001, 8'h00, 8'h00, 28'h0);
    chk("R12", "pop at top", bus_out, 28'h3333333);
    chk("R12", "sp wraps up", sp_out, 28'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_nop();
    t_sp_load();
    t_push_pop();
    t_push_imm();
    t_direct();
    t_upper_bits();
    t_idle();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule